// File: doc/BRIEF.md
# Event Dispatcher with Handler Activation Handshake

This block is a small event-driven control fabric. A single dispatcher watches an input port on which events arrive as a short burst of payload words, each paired with a code that names the handler that should take the event. The dispatcher resolves the code to one of several handler slots. It waits until that slot is free, then activates it through a fixed three-step handshake: it claims the slot, streams the payload into the slot's shared registers, and then starts it.

Each handler then runs its job without further help from the dispatcher. In this block a job is a programmable busy countdown, loaded from the first payload word. While a handler is busy, the dispatcher is already free to take the next event. Events for other slots can therefore run alongside it. An event for a busy slot waits in line at the input port. The dispatcher has no priority scheme and cannot preempt a running job.

Top module: `evt_dispatch_top`

## Requirements
- R1: While reset is asserted (synchronous, active high), and on the first cycle after it, the dispatcher and every handler are Idle, every shared register is zero, every done bit is 0 and `in_ready` is 0.
- R2: `in_ready` is 1 only while the dispatcher is in Transfer. The dispatcher stays in Idle as long as `in_valid` is 0.
- R3: If `in_valid` is seen in Idle while the target handler is not Idle, the dispatcher enters Wait. It keeps `in_ready` at 0, and leaves the target's registers untouched, until the target returns to Idle.
- R4: Activation order: the edge that accepts the event in Idle, with the target free, moves the dispatcher to Activate. The next edge moves the target from Idle to JobAdd and the dispatcher to Transfer. Payload words are then accepted one per cycle, word 0 first. The edge that accepts the last word moves the target to JobStart and the dispatcher back to Idle.
- R5: A handler in JobAdd stays there and does nothing else until the last payload word has been accepted.
- R6: A started handler spends max(word0, 1) cycles in JobStart and then one cycle in JobEnd. Its done bit is 1 exactly in that JobEnd cycle. The handler then returns to Idle.
- R7: After a transfer ends, the dispatcher accepts a new event for another handler while the previous handler is still counting, so several handlers can be in JobStart at once.
- R8: Payload word w of an event is written only into register w of the selected handler. Every other handler's registers keep their values.
- R9: Encodings: event code k selects handler k. `hnd_state[2k+1:2k]` reads Idle=0, JobAdd=1, JobStart=2, JobEnd=3. `disp_state` reads Idle=0, Wait=1, Activate=2, Transfer=3. Register w of handler h is `shared_regs[(3h+w)*16 +: 16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Event word present; held through all payload words |
| in_ready | output | 1 | Payload word accepted on this edge when `in_valid` is 1 |
| in_code | input | 2 | Target handler code, held constant through the event |
| in_data | input | 16 | Current payload word |
| disp_state | output | 2 | Dispatcher state |
| hnd_state | output | 8 | Packed handler states, 2 bits each |
| hnd_done | output | 4 | Per-handler one-cycle job completion pulse |
| shared_regs | output | 192 | Packed shared register banks of all handlers |

## Verification
The hardest situation to reach is an event held stalled in Wait behind a busy handler that shares its target. The stimulus starts a long countdown on one slot and then offers a second event for the same slot straight away. It watches the port stay stalled while the first job's registers keep their values, and then checks that the second payload is taken in only after the first done pulse. Concurrency is reached by starting a second slot while the first is still counting.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    D_IDLE = 2'd0,
    D_WAIT = 2'd1,
    D_ACT  = 2'd2,
    D_XFER = 2'd3
  } disp_state_t;

  typedef enum logic [1:0] {
    H_IDLE  = 2'd0,
    H_ADD   = 2'd1,
    H_START = 2'd2,
    H_END   = 2'd3
  } hnd_state_t;
endpackage

// File: rtl/evt_dispatcher.sv
module evt_dispatcher
  import evt_pkg::*;
#(
  parameter int N_HND  = 4,
  parameter int N_WORDS = 3,
  parameter int WORD_W = 16,
  localparam int CODE_W = (N_HND > 1) ? $clog2(N_HND) : 1,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [WORD_W-1:0] in_data,
  input  logic [N_HND-1:0]  h_idle,
  output logic [N_HND-1:0]  act_vec,
  output logic [N_HND-1:0]  wr_vec,
  output logic [N_HND-1:0]  start_vec,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic [1:0]        state_o
);
  disp_state_t      st;
  logic [CODE_W-1:0] tgt;
  logic [IDX_W-1:0]  idx;
  logic              last_word;
  logic [N_HND-1:0]  tgt_sel;
  logic              tgt_idle;

  assign last_word = (idx == IDX_W'(N_WORDS - 1));
  assign tgt_sel   = N_HND'(1) << tgt;
  assign tgt_idle  = h_idle[tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= D_IDLE;
      tgt <= '0;
      idx <= '0;
    end else begin
      case (st)
        D_IDLE: if (in_valid) begin
          tgt <= in_code;
          idx <= '0;
          st  <= h_idle[in_code] ? D_ACT : D_WAIT;
        end
        D_WAIT: if (tgt_idle) st <= D_ACT;
        D_ACT:  st <= D_XFER;
        D_XFER: if (in_valid) begin
          if (last_word) begin
            st  <= D_IDLE;
            idx <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready  = (st == D_XFER);
    act_vec   = (st == D_ACT) ? tgt_sel : '0;
    wr_vec    = (st == D_XFER && in_valid) ? tgt_sel : '0;
    start_vec = last_word ? wr_vec : '0;
    wr_idx    = idx;
    wr_data   = in_data;
    state_o   = st;
  end

  // R2: no departure from Idle without an offered event
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (st == D_IDLE && !in_valid) |=> (st == D_IDLE));
  // R4: a handler is only claimed while it reports Idle
  a_r4_act_target_idle: assert property (@(posedge clk) disable iff (rst)
    (st == D_ACT) |-> tgt_idle);
  // R3: Wait ends on the cycle after the target frees up
  a_r3_wait_release: assert property (@(posedge clk) disable iff (rst)
    (st == D_WAIT && tgt_idle) |=> (st == D_ACT));
  // R8: at most one handler is written at a time
  a_r8_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));
endmodule

// File: rtl/evt_handler.sv
module evt_handler
  import evt_pkg::*;
#(
  parameter int N_WORDS = 3,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      act,
  input  logic                      wr_en,
  input  logic                      start,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [1:0]                state_o,
  output logic                      done,
  output logic [N_WORDS*WORD_W-1:0] regs_flat
);
  hnd_state_t                    st;
  logic [N_WORDS-1:0][WORD_W-1:0] regs;
  logic [WORD_W-1:0]             cnt;
  logic [WORD_W-1:0]             word0_now;

  function automatic logic [WORD_W-1:0] job_cycles(input logic [WORD_W-1:0] w);
    return (w == '0) ? WORD_W'(1) : w;
  endfunction

  assign word0_now = (wr_en && wr_idx == '0) ? wr_data : regs[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= H_IDLE;
      regs <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        H_IDLE: if (act) st <= H_ADD;
        H_ADD: begin
          if (wr_en) regs[wr_idx] <= wr_data;
          if (start) begin
            cnt <= job_cycles(word0_now);
            st  <= H_START;
          end
        end
        H_START: begin
          if (cnt <= WORD_W'(1)) st <= H_END;
          else cnt <= cnt - WORD_W'(1);
        end
        H_END: st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

  assign state_o   = st;
  assign done      = (st == H_END);
  assign regs_flat = regs;

  // R6: done lasts exactly one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: JobEnd is only reached from JobStart
  a_r6_end_from_start: assert property (@(posedge clk) disable iff (rst)
    (st == H_END) |-> ($past(st) == H_START));
  // R5: JobAdd holds until the activator starts the job
  a_r5_add_holds: assert property (@(posedge clk) disable iff (rst)
    (st == H_ADD && !start) |=> (st == H_ADD));
  // R4: a job only starts out of JobAdd
  a_r4_start_from_add: assert property (@(posedge clk) disable iff (rst)
    (st == H_START && $past(st) != H_START) |-> ($past(st) == H_ADD));
endmodule

// File: rtl/evt_dispatch_top.sv
module evt_dispatch_top
  import evt_pkg::*;
#(
  parameter int N_HND   = 4,
  parameter int N_WORDS = 3,
  parameter int WORD_W  = 16,
  localparam int CODE_W = (N_HND > 1) ? $clog2(N_HND) : 1,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BANK_W = N_WORDS * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [WORD_W-1:0]       in_data,
  output logic [1:0]              disp_state,
  output logic [2*N_HND-1:0]      hnd_state,
  output logic [N_HND-1:0]        hnd_done,
  output logic [N_HND*BANK_W-1:0] shared_regs
);
  logic [N_HND-1:0]  h_idle;
  logic [N_HND-1:0]  act_vec;
  logic [N_HND-1:0]  wr_vec;
  logic [N_HND-1:0]  start_vec;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;

  evt_dispatcher #(.N_HND(N_HND), .N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_disp (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code), .in_data(in_data),
    .h_idle(h_idle), .act_vec(act_vec), .wr_vec(wr_vec), .start_vec(start_vec),
    .wr_idx(wr_idx), .wr_data(wr_data), .state_o(disp_state)
  );

  for (genvar g = 0; g < N_HND; g++) begin : g_hnd
    evt_handler #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_hnd (
      .clk(clk), .rst(rst),
      .act(act_vec[g]), .wr_en(wr_vec[g]), .start(start_vec[g]),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .state_o(hnd_state[2*g +: 2]), .done(hnd_done[g]),
      .regs_flat(shared_regs[g*BANK_W +: BANK_W])
    );
    assign h_idle[g] = (hnd_state[2*g +: 2] == H_IDLE);
  end

  // R2: the port only accepts during Transfer
  a_r2_ready_in_xfer: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (disp_state == D_XFER));
endmodule

// File: tb/evt_dispatch_top_tb.sv
`timescale 1ns/1ps
module evt_dispatch_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_code = '0;
  logic [15:0]  in_data = '0;
  logic [1:0]   disp_state;
  logic [7:0]   hnd_state;
  logic [3:0]   hnd_done;
  logic [191:0] shared_regs;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evt_dispatch_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_data(in_data), .disp_state(disp_state),
    .hnd_state(hnd_state), .hnd_done(hnd_done), .shared_regs(shared_regs)
  );

  function automatic logic [15:0] reg_of(input int h, input int w);
    return shared_regs[(3*h + w)*16 +: 16];
  endfunction

  function automatic logic [1:0] hst(input int h);
    return hnd_state[2*h +: 2];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int code, input logic [15:0] w0, input logic [15:0] w1,
                      input logic [15:0] w2);
    logic [15:0] w [3];
    int beat = 0;
    bit r;
    w[0] = w0; w[1] = w1; w[2] = w2;
    in_code = 2'(code);
    in_data = w[0];
    in_valid = 1'b1;
    check(in_ready == 1'b0, "R2", "ready before accept", in_ready, 0);
    while (beat < 3) begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) begin
        beat++;
        if (beat == 1)
          check(hst(code) == 2'd1, "R5", "JobAdd during transfer", hst(code), 1);
        if (beat < 3) in_data = w[beat];
        else in_valid = 1'b0;
      end
    end
    check(hst(code) == 2'd2, "R4", "JobStart after last word", hst(code), 2);
    check(disp_state == 2'd0, "R4", "dispatcher back to Idle", disp_state, 0);
  endtask

  task automatic wait_all_idle();
    while (hnd_state != 8'h00) @(negedge clk);
  endtask

  task automatic t_reset();
    check(disp_state == 2'd0, "R1", "dispatcher reset", disp_state, 0);
    check(hnd_state == 8'h00, "R1", "handlers reset", hnd_state, 0);
    check(shared_regs == '0, "R1", "regs reset", 0, 0);
    check(hnd_done == 4'h0 && in_ready == 1'b0, "R1", "done/ready reset", hnd_done, 0);
  endtask

  task automatic t_idle_no_valid();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(disp_state == 2'd0 && in_ready == 1'b0, "R2", "idle without valid", disp_state, 0);
    end
  endtask

  task automatic t_countdown(input int code, input logic [15:0] n, input int exp_cycles);
    int cyc = 0;
    send(code, n, 16'hA000 + 16'(code), 16'hB000 + 16'(code));
    check(reg_of(code, 0) == n, "R8", "word0 stored", reg_of(code, 0), n);
    check(reg_of(code, 2) == 16'hB000 + 16'(code), "R8", "word2 stored", reg_of(code, 2), 16'hB000 + code);
    while (hst(code) == 2'd2 && cyc < 100) begin
      check(hnd_done[code] == 1'b0, "R6", "no done while counting", hnd_done[code], 0);
      cyc++;
      @(negedge clk);
    end
    check(cyc == exp_cycles, "R6", "JobStart length", cyc, exp_cycles);
    check(hst(code) == 2'd3 && hnd_done[code] == 1'b1, "R6", "JobEnd with done", hst(code), 3);
    @(negedge clk);
    check(hst(code) == 2'd0 && hnd_done[code] == 1'b0, "R6", "back to Idle", hst(code), 0);
  endtask

  task automatic t_busy_target();
    send(2, 16'd40, 16'h1111, 16'h2222);
    fork
      send(2, 16'd2, 16'h3333, 16'h4444);
    join_none
    repeat (4) @(negedge clk);
    check(disp_state == 2'd1, "R3", "dispatcher in Wait", disp_state, 1);
    check(in_ready == 1'b0, "R3", "port stalled in Wait", in_ready, 0);
    check(reg_of(2, 1) == 16'h1111, "R3", "busy regs untouched", reg_of(2, 1), 16'h1111);
    while (hnd_done[2] == 1'b0) @(negedge clk);
    check(reg_of(2, 0) == 16'd40, "R3", "old job held until done", reg_of(2, 0), 40);
    wait fork;
    check(reg_of(2, 1) == 16'h3333 && reg_of(2, 2) == 16'h4444, "R3", "second payload after release",
          reg_of(2, 1), 16'h3333);
    wait_all_idle();
  endtask

  task automatic t_concurrent();
    send(0, 16'd20, 16'h0C01, 16'h0C02);
    send(3, 16'd20, 16'h3C01, 16'h3C02);
    check(hst(0) == 2'd2 && hst(3) == 2'd2, "R7", "two handlers running", hnd_state, 8'h82);
    check(reg_of(0, 1) == 16'h0C01, "R8", "first bank kept", reg_of(0, 1), 16'h0C01);
    wait_all_idle();
  endtask

  task automatic t_code_map();
    for (int k = 0; k < 4; k++) begin
      send(k, 16'd1, 16'(16'h5500 + k), 16'(16'h6600 + k));
      wait_all_idle();
    end
    for (int k = 0; k < 4; k++)
      check(reg_of(k, 1) == 16'(16'h5500 + k) && reg_of(k, 2) == 16'(16'h6600 + k),
            "R9", "code selects bank", reg_of(k, 1), 16'h5500 + k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_no_valid();
    t_countdown(1, 16'd3, 3);
    check(reg_of(0, 0) == 16'h0 && reg_of(3, 2) == 16'h0, "R8", "other banks zero", reg_of(0, 0), 0);
    t_countdown(1, 16'd0, 1);
    t_countdown(3, 16'd1, 1);
    t_busy_target();
    t_concurrent();
    t_code_map();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule